// File: doc/BRIEF.md
# Memory Bit Manipulation Unit

This unit carries out single-bit work on a byte-wide memory on behalf of a processor core. It accepts one command at a time: an operation code, a 16-bit operand, the current carry flag, an accumulator byte and a page flag. It reads the addressed byte through a simple synchronous memory port. Then it either combines one bit of that byte with the carry, or computes a modified byte and writes it back to the same address. It finishes with a one-cycle done pulse that carries the resulting carry and the negative and zero flags.

Most operations use a packed bit address. The low 13 bits name a byte and the top three bits name a bit within it. Direct-page set and clear take the opcode byte and a page offset in the operand instead. Test-and-set and test-and-clear use the whole operand as a byte address and mask the byte with the accumulator.

The command side is a valid/ready input. The unit raises ready only while idle, so the only back-pressure is that a source must hold valid until ready is seen. Results come back on a done pulse and cannot be stalled.

Top module: `membit_unit`

## Requirements
- R1: For operation codes 0 to 7, the operand is a bit address. Operand bits 12:0 are driven on mem_addr with mem_addr bits 15:13 at zero, and operand bits 15:13 select the bit (0 is the least significant).
- R2: The carry operations set res_carry as follows. Code 0 gives carry AND bit, code 1 gives carry AND NOT bit, code 2 gives carry OR bit, code 3 gives carry OR NOT bit, code 4 gives carry XOR bit, and code 5 loads the bit into the carry.
- R3: Codes 0 to 5 read the byte once and never assert mem_wr.
- R4: Code 6 writes the carry into the addressed bit. It leaves the other seven bits unchanged, writes to the address it read, and leaves res_carry equal to the input carry.
- R5: Code 7 inverts only the addressed bit and writes the byte back.
- R6: Code 8 is a direct-page set or clear. Operand bits 7:0 are the offset and operand bits 15:8 hold the opcode. Opcode bits 7:5 select the bit, and opcode bit 4 clears the bit when 1 and sets it when 0. The address is the offset plus 0x100 when cmd_page is 1, otherwise the offset alone.
- R7: Code 9 writes memory OR acc and code 10 writes memory AND NOT acc, both at the full 16-bit operand address.
- R8: For codes 9 and 10, res_neg is bit 7 and res_zero is the all-zero test of (memory AND acc), using the value read before the write. For every other code, res_neg and res_zero are 0.
- R9: cmd_ready is high only while the unit is idle, and a command is taken when cmd_valid and cmd_ready are both high. done is high for exactly one cycle per command.
- R10: mem_rd is asserted in the cycle after the command is taken. A write-back asserts mem_wr two cycles after mem_rd, and done follows one cycle after that. Without a write-back, done comes two cycles after mem_rd. mem_rd and mem_wr are never high together.
- R11: Codes 11 to 15 make no memory access. For them, done follows acceptance by one cycle, res_carry equals the input carry, and res_neg and res_zero are 0.
- R12: While in reset and after it, cmd_ready is 1 and mem_rd, mem_wr and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_op | input | 4 | Operation code |
| cmd_operand | input | 16 | Bit address, opcode and offset, or byte address |
| cmd_page | input | 1 | Direct-page select (adds 0x100) |
| cmd_carry | input | 1 | Current carry flag |
| cmd_acc | input | 8 | Accumulator mask for test ops |
| mem_rd | output | 1 | Read strobe, data returned next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| done | output | 1 | One-cycle completion pulse |
| res_carry | output | 1 | Resulting carry, valid with done |
| res_neg | output | 1 | Negative flag, valid with done |
| res_zero | output | 1 | Zero flag, valid with done |

## Verification
The bench pushes each carry operation against both a set bit and a clear bit, so a swapped complement or a misplaced bit select shows up as a wrong carry. It counts memory strobes per command, which catches any spurious write-back from a carry operation and any read issued for a reserved code. It sends an all-ones bit address to expose address bits leaking above bit 12, and it uses the same page offset with the page flag both set and clear. It also picks test operands where (memory AND acc) is zero or has bit 7 set, so flags computed from the written value instead of the pre-write value are caught.

// File: rtl/mbu_pkg.sv
package mbu_pkg;
  localparam int MEM_AW  = 16;
  localparam int BYTE_W  = 8;
  localparam int IDX_W   = $clog2(BYTE_W);
  localparam int BADDR_W = MEM_AW - IDX_W;
  localparam int OPC_W   = 4;
  localparam int CLR_POS = BYTE_W + 4;

  typedef enum logic [OPC_W-1:0] {
    OP_AND  = 4'd0,
    OP_ANDN = 4'd1,
    OP_OR   = 4'd2,
    OP_ORN  = 4'd3,
    OP_XOR  = 4'd4,
    OP_LDC  = 4'd5,
    OP_STC  = 4'd6,
    OP_TGL  = 4'd7,
    OP_DPB  = 4'd8,
    OP_TSET = 4'd9,
    OP_TCLR = 4'd10
  } mbu_op_e;

  typedef struct packed {
    logic [MEM_AW-1:0] addr;
    logic [IDX_W-1:0]  idx;
    logic              rd;
    logic              wr;
    logic              clr;
  } mbu_dec_t;
endpackage

// File: rtl/mbu_decode.sv
module mbu_decode
  import mbu_pkg::*;
(
  input  logic [OPC_W-1:0]  op,
  input  logic [MEM_AW-1:0] operand,
  input  logic              page,
  output mbu_dec_t          dec
);
  always_comb begin
    dec      = '0;
    dec.idx  = operand[MEM_AW-1 -: IDX_W];
    dec.clr  = operand[CLR_POS];
    case (op)
      OP_AND, OP_ANDN, OP_OR, OP_ORN, OP_XOR, OP_LDC: begin
        dec.addr = {{IDX_W{1'b0}}, operand[BADDR_W-1:0]};
        dec.rd   = 1'b1;
      end
      OP_STC, OP_TGL: begin
        dec.addr = {{IDX_W{1'b0}}, operand[BADDR_W-1:0]};
        dec.rd   = 1'b1;
        dec.wr   = 1'b1;
      end
      OP_DPB: begin
        dec.addr = {{(MEM_AW-BYTE_W-1){1'b0}}, page, operand[BYTE_W-1:0]};
        dec.rd   = 1'b1;
        dec.wr   = 1'b1;
      end
      OP_TSET, OP_TCLR: begin
        dec.addr = operand;
        dec.rd   = 1'b1;
        dec.wr   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mbu_bitalu.sv
module mbu_bitalu
  import mbu_pkg::*;
(
  input  logic [OPC_W-1:0]  op,
  input  logic [BYTE_W-1:0] mem_byte,
  input  logic [BYTE_W-1:0] acc,
  input  logic [IDX_W-1:0]  idx,
  input  logic              carry,
  input  logic              clr,
  output logic [BYTE_W-1:0] new_byte,
  output logic              new_carry,
  output logic              neg,
  output logic              zero
);
  logic [BYTE_W-1:0] sel_mask;
  logic [BYTE_W-1:0] tst;
  logic              bit_v;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
    assign sel_mask[i] = (idx == IDX_W'(i));
  end

  assign bit_v = |(mem_byte & sel_mask);
  assign tst   = mem_byte & acc;

  always_comb begin
    new_byte  = mem_byte;
    new_carry = carry;
    neg       = 1'b0;
    zero      = 1'b0;
    case (op)
      OP_AND:  new_carry = carry & bit_v;
      OP_ANDN: new_carry = carry & ~bit_v;
      OP_OR:   new_carry = carry | bit_v;
      OP_ORN:  new_carry = carry | ~bit_v;
      OP_XOR:  new_carry = carry ^ bit_v;
      OP_LDC:  new_carry = bit_v;
      OP_STC:  new_byte  = carry ? (mem_byte | sel_mask) : (mem_byte & ~sel_mask);
      OP_TGL:  new_byte  = mem_byte ^ sel_mask;
      OP_DPB:  new_byte  = clr ? (mem_byte & ~sel_mask) : (mem_byte | sel_mask);
      OP_TSET: begin
        new_byte = mem_byte | acc;
        neg      = tst[BYTE_W-1];
        zero     = (tst == '0);
      end
      OP_TCLR: begin
        new_byte = mem_byte & ~acc;
        neg      = tst[BYTE_W-1];
        zero     = (tst == '0);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/membit_unit.sv
module membit_unit
  import mbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OPC_W-1:0]  cmd_op,
  input  logic [MEM_AW-1:0] cmd_operand,
  input  logic              cmd_page,
  input  logic              cmd_carry,
  input  logic [BYTE_W-1:0] cmd_acc,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              done,
  output logic              res_carry,
  output logic              res_neg,
  output logic              res_zero
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_CAP, S_WR, S_DN} state_e;

  state_e            st;
  mbu_dec_t          dec, dec_q;
  logic [OPC_W-1:0]  op_q;
  logic              carry_q;
  logic [BYTE_W-1:0] acc_q, byte_q, wdata_q, alu_byte;
  logic              alu_carry, alu_neg, alu_zero;

  mbu_decode u_dec (
    .op(cmd_op), .operand(cmd_operand), .page(cmd_page), .dec(dec)
  );

  mbu_bitalu u_alu (
    .op(op_q), .mem_byte(mem_rdata), .acc(acc_q), .idx(dec_q.idx),
    .carry(carry_q), .clr(dec_q.clr), .new_byte(alu_byte),
    .new_carry(alu_carry), .neg(alu_neg), .zero(alu_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      dec_q     <= '0;
      op_q      <= '0;
      carry_q   <= 1'b0;
      acc_q     <= '0;
      byte_q    <= '0;
      wdata_q   <= '0;
      res_carry <= 1'b0;
      res_neg   <= 1'b0;
      res_zero  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q      <= cmd_op;
          dec_q     <= dec;
          carry_q   <= cmd_carry;
          acc_q     <= cmd_acc;
          res_carry <= cmd_carry;
          res_neg   <= 1'b0;
          res_zero  <= 1'b0;
          st        <= dec.rd ? S_RD : S_DN;
        end
        S_RD: st <= S_CAP;
        S_CAP: begin
          byte_q    <= mem_rdata;
          wdata_q   <= alu_byte;
          res_carry <= alu_carry;
          res_neg   <= alu_neg;
          res_zero  <= alu_zero;
          st        <= dec_q.wr ? S_WR : S_DN;
        end
        S_WR:    st <= S_DN;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == S_IDLE);
  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WR);
  assign mem_addr  = dec_q.addr;
  assign mem_wdata = wdata_q;
  assign done      = (st == S_DN);

  assert_bitaddr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && op_q <= OP_TGL) |-> mem_addr[MEM_AW-1 -: IDX_W] == '0);

  assert_no_carry_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (op_q == OP_STC || op_q == OP_TGL || op_q == OP_DPB ||
                op_q == OP_TSET || op_q == OP_TCLR));

  assert_same_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr == $past(mem_addr, 2));

  assert_single_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && (op_q == OP_STC || op_q == OP_TGL || op_q == OP_DPB))
      |-> $countones(mem_wdata ^ byte_q) <= 1);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_rd && !mem_wr && !done);

  assert_wr_after_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 2));

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

// File: tb/membit_unit_test.sv
module membit_unit_test;
  import mbu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [15:0] cmd_operand = '0;
  logic        cmd_page = 1'b0;
  logic        cmd_carry = 1'b0;
  logic [7:0]  cmd_acc = '0;
  logic        mem_rd, mem_wr, done, res_carry, res_neg, res_zero;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  always #5 clk = ~clk;

  membit_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_operand(cmd_operand), .cmd_page(cmd_page),
    .cmd_carry(cmd_carry), .cmd_acc(cmd_acc), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .res_carry(res_carry), .res_neg(res_neg), .res_zero(res_zero)
  );

  typedef struct {
    string       tag;
    logic        carry, n, z;
    int          nrd, nwr;
    logic [15:0] addr;
    logic [7:0]  wdata;
  } exp_t;

  exp_t q[$];
  exp_t e_cur;
  int n_tests = 0, n_fail = 0;
  int cyc = 0, acc_cyc = 0, rd_cyc = 0, wr_cyc = 0;
  int rd_cnt = 0, wr_cnt = 0, rd_snap = 0, wr_snap = 0;
  logic [15:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [7:0]  last_wdata = '0;
  logic [7:0]  mem_m [0:255];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory model: read data returned one cycle after the strobe
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_m[i] <= 8'(i);
    end else begin
      if (cmd_valid && cmd_ready) acc_cyc <= cyc;
      if (mem_rd) begin
        mem_rdata    <= mem_m[mem_addr[7:0]];
        rd_cnt       <= rd_cnt + 1;
        last_rd_addr <= mem_addr;
        rd_cyc       <= cyc;
      end
      if (mem_wr) begin
        mem_m[mem_addr[7:0]] <= mem_wdata;
        wr_cnt       <= wr_cnt + 1;
        last_wr_addr <= mem_addr;
        last_wdata   <= mem_wdata;
        wr_cyc       <= cyc;
      end
    end
    cyc <= cyc + 1;
  end

  // monitor: pops expected items on each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk("R9 unexpected done", 1, 0);
      end else begin
        e_cur = q.pop_front();
        chk({e_cur.tag, " R2 carry"}, res_carry, e_cur.carry);
        chk({e_cur.tag, " R8 neg"}, res_neg, e_cur.n);
        chk({e_cur.tag, " R8 zero"}, res_zero, e_cur.z);
        chk({e_cur.tag, " R3 reads"}, rd_cnt - rd_snap, e_cur.nrd);
        chk({e_cur.tag, " R3 writes"}, wr_cnt - wr_snap, e_cur.nwr);
        if (e_cur.nrd == 1) begin
          chk({e_cur.tag, " R1 read addr"}, last_rd_addr, e_cur.addr);
          chk({e_cur.tag, " R10 rd timing"}, rd_cyc, acc_cyc + 1);
          if (e_cur.nwr == 1) begin
            chk({e_cur.tag, " R4 write addr"}, last_wr_addr, e_cur.addr);
            chk({e_cur.tag, " R5 write data"}, last_wdata, e_cur.wdata);
            chk({e_cur.tag, " R10 wr timing"}, wr_cyc, rd_cyc + 2);
            chk({e_cur.tag, " R10 done timing"}, cyc, wr_cyc + 1);
          end else begin
            chk({e_cur.tag, " R10 done timing"}, cyc, rd_cyc + 2);
          end
        end else begin
          chk({e_cur.tag, " R11 done timing"}, cyc, acc_cyc + 1);
        end
        rd_snap = rd_cnt;
        wr_snap = wr_cnt;
      end
    end
  end

  // driver: computes the expected result from the requirements, then issues
  task automatic issue(input string tag, input logic [3:0] op, input logic [15:0] operand,
                       input logic carry, input logic [7:0] acc, input logic page);
    exp_t        e;
    logic [15:0] a;
    logic [2:0]  ix;
    logic [7:0]  old, tst;
    logic        bv;
    ix = operand[15:13];
    a  = '0;
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: a = {3'b000, operand[12:0]};
      4'd8: a = {7'd0, page, operand[7:0]};
      4'd9, 4'd10: a = operand;
      default: a = '0;
    endcase
    old = mem_m[a[7:0]];
    bv  = old[ix];
    tst = old & acc;
    e.tag = tag; e.carry = carry; e.n = 1'b0; e.z = 1'b0;
    e.nrd = 1; e.nwr = 0; e.addr = a; e.wdata = old;
    case (op)
      4'd0: e.carry = carry & bv;
      4'd1: e.carry = carry & ~bv;
      4'd2: e.carry = carry | bv;
      4'd3: e.carry = carry | ~bv;
      4'd4: e.carry = carry ^ bv;
      4'd5: e.carry = bv;
      4'd6: begin e.nwr = 1; e.wdata[ix] = carry; end
      4'd7: begin e.nwr = 1; e.wdata[ix] = ~bv; end
      4'd8: begin e.nwr = 1; e.wdata[operand[15:13]] = ~operand[12]; end
      4'd9: begin e.nwr = 1; e.wdata = old | acc; e.n = tst[7]; e.z = (tst == 0); end
      4'd10: begin e.nwr = 1; e.wdata = old & ~acc; e.n = tst[7]; e.z = (tst == 0); end
      default: e.nrd = 0;
    endcase
    q.push_back(e);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_operand = operand;
    cmd_carry = carry; cmd_acc = acc; cmd_page = page;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 ready in reset", cmd_ready, 1);
    chk("R12 rd in reset", mem_rd, 0);
    chk("R12 wr in reset", mem_wr, 0);
    chk("R12 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 ready after reset", cmd_ready, 1);
    // R2 carry logic, bit set and bit clear
    issue("R2 and set",   OP_AND,  {3'd3, 13'h000F}, 1'b1, 8'h00, 1'b0);
    issue("R2 and clr",   OP_AND,  {3'd5, 13'h000F}, 1'b1, 8'h00, 1'b0);
    issue("R2 andn",      OP_ANDN, {3'd5, 13'h000F}, 1'b1, 8'h00, 1'b0);
    issue("R2 or",        OP_OR,   {3'd7, 13'h0080}, 1'b0, 8'h00, 1'b0);
    issue("R2 orn set",   OP_ORN,  {3'd7, 13'h0080}, 1'b0, 8'h00, 1'b0);
    issue("R2 orn clr",   OP_ORN,  {3'd0, 13'h0080}, 1'b0, 8'h00, 1'b0);
    issue("R2 xor",       OP_XOR,  {3'd0, 13'h0001}, 1'b1, 8'h00, 1'b0);
    issue("R2 ldc one",   OP_LDC,  {3'd6, 13'h0040}, 1'b0, 8'h00, 1'b0);
    issue("R2 ldc zero",  OP_LDC,  {3'd2, 13'h0000}, 1'b1, 8'h00, 1'b0);
    // R1 all-ones bit address: byte 0x1FFF, bit 7
    issue("R1 top addr",  OP_LDC,  16'hFFFF, 1'b0, 8'h00, 1'b0);
    // R4 store carry
    issue("R4 stc one",   OP_STC,  {3'd0, 13'h0020}, 1'b1, 8'h00, 1'b0);
    issue("R4 stc zero",  OP_STC,  {3'd5, 13'h0130}, 1'b0, 8'h00, 1'b0);
    // R5 toggle then read back
    issue("R5 toggle",    OP_TGL,  {3'd1, 13'h0055}, 1'b0, 8'h00, 1'b0);
    issue("R5 readback",  OP_LDC,  {3'd1, 13'h0055}, 1'b0, 8'h00, 1'b0);
    // R6 direct page: opcode 0x62 sets bit 3, 0x52 clears bit 2
    issue("R6 set page1", OP_DPB,  16'h6244, 1'b0, 8'h00, 1'b1);
    issue("R6 clr page0", OP_DPB,  16'h5244, 1'b1, 8'h00, 1'b0);
    // R7/R8 test-and-set / test-and-clear
    issue("R7 tset",      OP_TSET, 16'hABCD, 1'b1, 8'h0F, 1'b0);
    issue("R8 tclr zero", OP_TCLR, 16'h9003, 1'b0, 8'hF0, 1'b0);
    issue("R8 tset neg",  OP_TSET, 16'h00F0, 1'b0, 8'h80, 1'b0);
    // R11 reserved code
    issue("R11 reserved", 4'd12,   16'h1234, 1'b1, 8'hFF, 1'b1);
    chk("R9 ready at end", cmd_ready, 1);
    chk("R9 queue empty", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule